// File: doc/BRIEF.md
# Quadrant-Selectable Memory Parity Checker

This block sits beside a memory array and guards its 16-bit data words with one extra parity bit. The address space is split into equal regions, four by default, selected by the top address bits. Each region has its own enable bit in a control register, and a separate control bit chooses odd or even parity. When a write goes to an enabled region, the block drives the parity bit that the array stores next to the data word. When a read comes from an enabled region, the block recomputes parity over the returned data, compares it with the stored bit, and pulses an error in the same cycle.

The first failing read has its address captured in a holding register, and a sticky flag is set. Later failures leave both untouched until software clears the flag through the register port. Accesses to disabled regions pass through unguarded: no parity is written, no error is raised, and nothing is captured.

Top module: `mem_parity_guard`

## Requirements
- R1: After reset the control register reads 0, so all regions are disabled and even parity is selected. The status flag reads 0. `parErr` and `parWrEn` are low.
- R2: The region index is the top `REGION_BITS` bits of `cycAddr`. Control bit i (bit 0 up to bit NUM_REGIONS-1) enables region i. For the default 16-bit address, region 0 is 0000-3FFF and region 3 is C000-FFFF.
- R3: In a cycle with `cycValid`=1, `cycWrite`=1 and the addressed region enabled, `parWrEn` is 1 and `parOut` is the parity bit over `cycData`. With even parity, the 17 bits taken together hold an even number of ones. With odd parity they hold an odd number.
- R4: Control bit NUM_REGIONS (bit 4 by default) selects odd parity when 1 and even parity when 0.
- R5: In a cycle with `cycValid`=1, `cycWrite`=0 and the addressed region enabled, `parErr` is 1 in that same cycle exactly when `cycData` and `cycParIn` together violate the selected parity. A read with correct parity gives `parErr`=0.
- R6: An access to a disabled region never asserts `parErr` or `parWrEn`, and it leaves the status flag and the failing address unchanged.
- R7: On a parity error while the status flag is 0, the failing address register takes `cycAddr` and the flag becomes 1. Both can be read from the next cycle on.
- R8: While the flag is 1, further errors still pulse `parErr`, but the failing address stays frozen.
- R9: A register write to the status register with bit 0 = 1 clears the flag. A write with bit 0 = 0 has no effect. If an error occurs in the same cycle as a clear, it is captured and the flag stays 1.
- R10: Register select codes: 0 is control (writable; unused bits read 0), 1 is the failing address (read-only), 2 is status with the flag in bit 0, and 3 reads 0. Writes to codes 1 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cycValid | input | 1 | Memory cycle strobe, one cycle per access |
| cycWrite | input | 1 | 1 = write cycle, 0 = read cycle |
| cycAddr | input | ADDR_W | Access address |
| cycData | input | DATA_W | Write data, or read data returned by the array |
| cycParIn | input | 1 | Stored parity bit returned with read data |
| parOut | output | 1 | Parity bit to store on a guarded write |
| parWrEn | output | 1 | Store enable for the parity bit |
| parErr | output | 1 | Parity error pulse in the read cycle |
| regWr | input | 1 | Register write strobe |
| regSel | input | 2 | Register select |
| regWdata | input | REG_W | Register write data |
| regRdata | output | REG_W | Register read data for `regSel` |

## Verification
The bench uses the default parameters: 16-bit addresses, 16-bit data and two region bits, so there are four quadrants. This lets every region boundary be hit with the literal addresses 0000, 4000, 8000 and C000. Both parity senses are driven with data words that have an even and an odd number of ones. A clear request and a new failure are placed in the same cycle to show which one wins.

// File: rtl/mpg_pkg.sv
package mpg_pkg;
  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_FADDR  = 2'd1;
  localparam logic [1:0] SEL_STATUS = 2'd2;

  typedef struct packed {
    logic genPar;     // guarded write in progress
    logic chkPar;     // guarded read in progress
    logic capture;    // load failing address, set flag
    logic clearFlag;  // software clear of sticky flag
    logic wrCtrl;     // load control register
  } mpgStrobes_t;
endpackage

// File: rtl/mpg_ctrl.sv
module mpg_ctrl
  import mpg_pkg::*;
#(
  parameter int REGION_BITS = 2,
  localparam int NUM_REGIONS = 1 << REGION_BITS
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   cycValid,
  input  logic                   cycWrite,
  input  logic [REGION_BITS-1:0] cycRegion,
  input  logic [NUM_REGIONS-1:0] regionEn,
  input  logic                   mismatch,
  input  logic                   failValid,
  input  logic                   regWr,
  input  logic [1:0]             regSel,
  input  logic                   regClrBit,
  output mpgStrobes_t            strb,
  output logic                   parErr
);
  logic [NUM_REGIONS-1:0] regionHit;
  logic                   guarded;

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    assign regionHit[i] = (cycRegion == REGION_BITS'(i)) && regionEn[i];
  end

  assign guarded = cycValid && (|regionHit);

  always_comb begin
    strb           = '0;
    strb.genPar    = guarded && cycWrite;
    strb.chkPar    = guarded && !cycWrite;
    strb.clearFlag = regWr && (regSel == SEL_STATUS) && regClrBit;
    strb.wrCtrl    = regWr && (regSel == SEL_CTRL);
    strb.capture   = strb.chkPar && mismatch && (!failValid || strb.clearFlag);
  end

  assign parErr = strb.chkPar && mismatch;

  // R5: an error only ever appears in a read strobe cycle
  p_err_in_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    parErr |-> (cycValid && !cycWrite));
  // R3: parity store only in a write strobe cycle
  p_gen_in_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.genPar |-> (cycValid && cycWrite));
  // R6: disabled region never guarded
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !regionEn[cycRegion]) |-> !(strb.genPar || strb.chkPar));
endmodule

// File: rtl/mpg_dpath.sv
module mpg_dpath
  import mpg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int REGION_BITS = 2,
  parameter int REG_W       = 16,
  localparam int NUM_REGIONS = 1 << REGION_BITS,
  localparam int CTRL_W      = NUM_REGIONS + 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  mpgStrobes_t            strb,
  input  logic [ADDR_W-1:0]      cycAddr,
  input  logic [DATA_W-1:0]      cycData,
  input  logic                   cycParIn,
  input  logic [1:0]             regSel,
  input  logic [CTRL_W-1:0]      ctrlWdata,
  output logic [NUM_REGIONS-1:0] regionEn,
  output logic                   mismatch,
  output logic                   failValid,
  output logic                   parOut,
  output logic [REG_W-1:0]       regRdata
);
  logic [CTRL_W-1:0] ctrlReg;
  logic [ADDR_W-1:0] failAddr;
  logic              oddSel;
  logic              parBit;

  assign regionEn = ctrlReg[NUM_REGIONS-1:0];
  assign oddSel   = ctrlReg[NUM_REGIONS];
  assign parBit   = (^cycData) ^ oddSel;
  assign mismatch = ((^cycData) ^ cycParIn) != oddSel;
  assign parOut   = strb.genPar ? parBit : 1'b0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      failAddr  <= '0;
      failValid <= 1'b0;
    end else begin
      if (strb.wrCtrl) ctrlReg <= ctrlWdata;
      if (strb.capture) begin
        failAddr  <= cycAddr;
        failValid <= 1'b1;
      end else if (strb.clearFlag) begin
        failValid <= 1'b0;
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regSel)
      SEL_CTRL:   regRdata[CTRL_W-1:0] = ctrlReg;
      SEL_FADDR:  regRdata[ADDR_W-1:0] = failAddr;
      SEL_STATUS: regRdata[0]          = failValid;
      default:    regRdata             = '0;
    endcase
  end

  // R7: capture loads the access address and sets the flag
  p_capture_loads_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (failValid && failAddr == $past(cycAddr)));
  // R8: held address frozen until a clear
  p_addr_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (failValid && !strb.clearFlag) |=> ($stable(failAddr) && failValid));
  // R9: a clear without a coincident capture drops the flag
  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clearFlag && !strb.capture) |=> !failValid);
endmodule

// File: rtl/mem_parity_guard.sv
module mem_parity_guard
  import mpg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int REGION_BITS = 2,
  parameter int REG_W       = 16,
  localparam int NUM_REGIONS = 1 << REGION_BITS,
  localparam int CTRL_W      = NUM_REGIONS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cycValid,
  input  logic              cycWrite,
  input  logic [ADDR_W-1:0] cycAddr,
  input  logic [DATA_W-1:0] cycData,
  input  logic              cycParIn,
  output logic              parOut,
  output logic              parWrEn,
  output logic              parErr,
  input  logic              regWr,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  regWdata,
  output logic [REG_W-1:0]  regRdata
);
  mpgStrobes_t            strb;
  logic [NUM_REGIONS-1:0] regionEn;
  logic                   mismatch;
  logic                   failValid;
  logic                   unusedWdata;

  assign unusedWdata = ^regWdata[REG_W-1:CTRL_W];

  mpg_ctrl #(.REGION_BITS(REGION_BITS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cycValid  (cycValid),
    .cycWrite  (cycWrite),
    .cycRegion (cycAddr[ADDR_W-1 -: REGION_BITS]),
    .regionEn  (regionEn),
    .mismatch  (mismatch),
    .failValid (failValid),
    .regWr     (regWr),
    .regSel    (regSel),
    .regClrBit (regWdata[0]),
    .strb      (strb),
    .parErr    (parErr)
  );

  mpg_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REGION_BITS(REGION_BITS), .REG_W(REG_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cycAddr   (cycAddr),
    .cycData   (cycData),
    .cycParIn  (cycParIn),
    .regSel    (regSel),
    .ctrlWdata (regWdata[CTRL_W-1:0]),
    .regionEn  (regionEn),
    .mismatch  (mismatch),
    .failValid (failValid),
    .parOut    (parOut),
    .regRdata  (regRdata)
  );

  assign parWrEn = strb.genPar;

  // R1: outputs idle in the first cycle after reset
  p_idle_after_reset_r1: assert property (@(posedge clk)
    $rose(rstN) |-> (!parErr && !parWrEn));
endmodule

// File: tb/sim_mem_parity_guard.sv
module sim_mem_parity_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cycValid = 1'b0, cycWrite = 1'b0, cycParIn = 1'b0;
  logic [15:0] cycAddr = '0, cycData = '0;
  logic        parOut, parWrEn, parErr;
  logic        regWr = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWdata = '0, regRdata;

  int nTests = 0, nFail = 0;
  logic sErr, sWe, sPar;
  logic [15:0] rd;

  always #5 clk = ~clk;

  mem_parity_guard u0 (.*);

  initial begin
    #500000;
    nFail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic goodPar(input logic [15:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  task automatic memCycle(input logic wr, input logic [15:0] a, input logic [15:0] d, input logic p);
    @(negedge clk);
    cycValid = 1'b1; cycWrite = wr; cycAddr = a; cycData = d; cycParIn = p;
    #2; sErr = parErr; sWe = parWrEn; sPar = parOut;
    @(negedge clk);
    cycValid = 1'b0;
  endtask

  task automatic regWrite(input logic [1:0] s, input logic [15:0] d);
    @(negedge clk);
    regWr = 1'b1; regSel = s; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] s, output logic [15:0] v);
    @(negedge clk);
    regSel = s;
    #2 v = regRdata;
  endtask

  task automatic t_reset;
    regRead(2'd0, rd); check("R1 ctrl", rd, 16'h0000);
    regRead(2'd2, rd); check("R1 status", rd, 16'h0000);
    memCycle(1'b0, 16'h0100, 16'h0001, 1'b0);
    check("R1 no err", {15'd0, sErr}, 16'd0);
  endtask

  task automatic t_generate;
    regWrite(2'd0, 16'h000F);
    memCycle(1'b1, 16'h1234, 16'h0001, 1'b0);
    check("R3 we", {15'd0, sWe}, 16'd1);
    check("R3 even par", {15'd0, sPar}, 16'd1);
    memCycle(1'b1, 16'h1234, 16'h0003, 1'b0);
    check("R3 even par2", {15'd0, sPar}, 16'd0);
    regWrite(2'd0, 16'h001F);
    memCycle(1'b1, 16'hF000, 16'h0001, 1'b0);
    check("R4 odd par", {15'd0, sPar}, 16'd0);
    memCycle(1'b1, 16'hF000, 16'h0000, 1'b0);
    check("R4 odd par zero", {15'd0, sPar}, 16'd1);
  endtask

  task automatic t_quadrants;
    regWrite(2'd0, 16'h0004);
    memCycle(1'b1, 16'h8000, 16'h0007, 1'b0);
    check("R2 q2 low edge we", {15'd0, sWe}, 16'd1);
    memCycle(1'b1, 16'h7FFF, 16'h0007, 1'b0);
    check("R6 q1 write no we", {15'd0, sWe}, 16'd0);
    memCycle(1'b1, 16'hC000, 16'h0007, 1'b0);
    check("R6 q3 write no we", {15'd0, sWe}, 16'd0);
    memCycle(1'b0, 16'h0000, 16'h0001, 1'b0);
    check("R6 disabled bad read no err", {15'd0, sErr}, 16'd0);
    regRead(2'd2, rd); check("R6 flag untouched", rd, 16'd0);
    regRead(2'd1, rd); check("R6 addr untouched", rd, 16'd0);
    memCycle(1'b0, 16'hBFFF, 16'h0001, 1'b0);
    check("R2 q2 high edge err", {15'd0, sErr}, 16'd1);
    regWrite(2'd2, 16'h0001);
  endtask

  task automatic t_check;
    regWrite(2'd0, 16'h000F);
    memCycle(1'b0, 16'h4321, 16'h00F1, goodPar(16'h00F1, 1'b0));
    check("R5 good read", {15'd0, sErr}, 16'd0);
    memCycle(1'b0, 16'hC123, 16'h00F1, ~goodPar(16'h00F1, 1'b0));
    check("R5 bad read", {15'd0, sErr}, 16'd1);
    regRead(2'd2, rd); check("R7 flag set", rd, 16'd1);
    regRead(2'd1, rd); check("R7 addr", rd, 16'hC123);
    memCycle(1'b0, 16'h0042, 16'h0000, 1'b1);
    check("R8 err still pulses", {15'd0, sErr}, 16'd1);
    regRead(2'd1, rd); check("R8 addr frozen", rd, 16'hC123);
    regWrite(2'd2, 16'h0000);
    regRead(2'd2, rd); check("R9 write0 keeps", rd, 16'd1);
    regWrite(2'd2, 16'h0001);
    regRead(2'd2, rd); check("R9 clear", rd, 16'd0);
    memCycle(1'b0, 16'h0042, 16'h0000, 1'b1);
    regRead(2'd1, rd); check("R7 recapture", rd, 16'h0042);
    regWrite(2'd0, 16'h001F);
    memCycle(1'b0, 16'h5000, 16'h0000, 1'b0);
    check("R4 odd check err", {15'd0, sErr}, 16'd1);
  endtask

  task automatic t_collision;
    @(negedge clk);
    cycValid = 1'b1; cycWrite = 1'b0; cycAddr = 16'h9ABC; cycData = 16'h0000; cycParIn = 1'b0;
    regWr = 1'b1; regSel = 2'd2; regWdata = 16'h0001;
    @(negedge clk);
    cycValid = 1'b0; regWr = 1'b0;
    regRead(2'd2, rd); check("R9 collision flag", rd, 16'd1);
    regRead(2'd1, rd); check("R9 collision addr", rd, 16'h9ABC);
  endtask

  task automatic t_regmap;
    regWrite(2'd1, 16'hFFFF);
    regRead(2'd1, rd); check("R10 faddr read-only", rd, 16'h9ABC);
    regWrite(2'd3, 16'hFFFF);
    regRead(2'd3, rd); check("R10 sel3 zero", rd, 16'h0000);
    regRead(2'd0, rd); check("R10 ctrl unaffected", rd, 16'h001F);
    regWrite(2'd0, 16'hFFE0);
    regRead(2'd0, rd); check("R10 ctrl unused bits", rd, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_generate();
    t_quadrants();
    t_check();
    t_collision();
    t_regmap();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule